// File: doc/BRIEF.md
# Comparator Output Conditioner

This block takes the raw, possibly chattering level from an analog voltage comparator and turns it into clean digital events. The raw level is high while the comparator's positive input is above its negative input and low otherwise. It is brought into the peripheral clock domain by a two-stage synchroniser. It then passes through a debounce filter whose hold time can be set to 0, 1, 2 or 3 clock cycles.

Changes on the filtered level drive two consumers. The first is a sticky interrupt flag that is set by one selectable edge direction and is cleared by software. The interrupt line is that flag gated by an enable. The second is a one-cycle wake request that fires on every change, in either direction, but only while the power-mode input reports light sleep. An edge that wakes the system and also matches the selected interrupt direction sets the flag in the same cycle, so the interrupt is taken right after waking.

Top module: `cmp_cond`

## Requirements
- R1: With debounce select 0, `level_o` follows `cmp_raw_i` with no filtering. A change on the raw input appears on `level_o` in the cycle after the second rising clock edge that follows the change, which is the latency of the two synchroniser stages.
- R2: With debounce select N (1..3), `level_o` takes a new level only after the synchronised input has differed from it on N consecutive clock edges. The new level appears N edges later than it would with select 0.
- R3: If the synchronised input returns to the current filtered level before the hold time has elapsed, the count restarts and `level_o` does not change.
- R4: `edge_fall_i` = 0 selects rising edges of `level_o` as the interrupt trigger, and 1 selects falling edges. The flag is set on the clock edge that follows the change on `level_o`.
- R5: Once set, `flag_o` stays at 1 until `flag_clr_i` is high on a clock edge and no trigger edge arrives on that same clock edge.
- R6: When a software clear and a trigger edge arrive on the same clock edge, the flag ends up set.
- R7: `irq_o` is high exactly when `flag_o` is high and `irq_en_i` is high.
- R8: `wake_o` pulses high for one cycle on the clock edge after any change of `level_o` if `pmode_i` was 1 (sleep). It stays low when `pmode_i` is 0 (run), 2 (deep sleep) or 3 (power-down).
- R9: While reset is held and just after its release, `level_o`, `flag_o`, `irq_o` and `wake_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Raw comparator output, asynchronous |
| dbsel_i | input | 2 | Debounce hold time in clock cycles (0 = off) |
| edge_fall_i | input | 1 | Interrupt edge: 0 rising, 1 falling |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Software clear of the interrupt flag |
| pmode_i | input | 2 | Power mode: 0 run, 1 sleep, 2 deep sleep, 3 power-down |
| level_o | output | 1 | Filtered comparator level |
| flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Interrupt request (flag AND enable) |
| wake_o | output | 1 | One-cycle wake-up request |

## Verification
The hardest situation to reach is a software clear that lands on exactly the clock edge where a debounced trigger edge sets the flag. That edge lies a fixed number of synchroniser and filter stages behind the raw input change. The directed case counts those stages from the moment the raw input is driven and places the clear on that edge. Random stimulus then mixes short bursts of raw toggling with long holds, under changing debounce, edge, enable and power-mode settings. This makes glitches shorter than the hold time arise naturally, and every cycle is compared against a bench model of the requirements.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  localparam int DB_SEL_W = 2;
  localparam int PM_W     = 2;

  typedef enum logic [PM_W-1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_DEEP  = 2'd2,
    PM_OFF   = 2'd3
  } pmode_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stg_d[i] = d_i;
      end else begin : g_next
        assign stg_d[i] = stg_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cmp_debounce.sv
module cmp_debounce #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             dout_o
);
  localparam int CNT_W = SEL_W;

  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bypass;
  logic             differs;
  logic [CNT_W:0]   cnt_inc;
  logic             held;
  logic             upd_en;

  assign bypass  = (sel_i == '0);
  assign differs = (din_i != filt_q);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign held    = (cnt_inc >= {1'b0, sel_i});

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (bypass) begin
      filt_d = din_i;
      cnt_d  = '0;
    end else if (!differs) begin
      cnt_d  = '0;
    end else if (held) begin
      filt_d = din_i;
      cnt_d  = '0;
    end else begin
      cnt_d  = cnt_inc[CNT_W-1:0];
    end
  end

  assign upd_en = (filt_d != filt_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dout_o = bypass ? din_i : filt_q;
endmodule

// File: rtl/cmp_event.sv
module cmp_event
  import cmp_cond_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lvl_i,
  input  logic            fall_sel_i,
  input  logic            irq_en_i,
  input  logic            clr_i,
  input  logic [PM_W-1:0] pmode_i,
  output logic            flag_o,
  output logic            irq_o,
  output logic            wake_o
);
  logic lvl_q;
  logic flag_q, flag_d, flag_en;
  logic wake_q, wake_d;
  logic any_edge, trig;

  assign any_edge = (lvl_i != lvl_q);
  assign trig     = any_edge && (lvl_i == !fall_sel_i);

  always_comb begin
    flag_d  = flag_q;
    flag_en = trig || clr_i;
    if (trig)       flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    wake_d = any_edge && (pmode_e'(pmode_i) == PM_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      wake_q <= wake_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && irq_en_i;
  assign wake_o = wake_q;
endmodule

// File: rtl/cmp_cond.sv
module cmp_cond
  import cmp_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_raw_i,
  input  logic [DB_SEL_W-1:0] dbsel_i,
  input  logic                edge_fall_i,
  input  logic                irq_en_i,
  input  logic                flag_clr_i,
  input  logic [PM_W-1:0]     pmode_i,
  output logic                level_o,
  output logic                flag_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [1:0] rst_q;
  logic       rst_int_n;
  logic       raw_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (cmp_raw_i),
    .q_o   (raw_sync)
  );

  cmp_debounce #(.SEL_W(DB_SEL_W)) u_db (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din_i  (raw_sync),
    .sel_i  (dbsel_i),
    .dout_o (level_o)
  );

  cmp_event u_evt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lvl_i      (level_o),
    .fall_sel_i (edge_fall_i),
    .irq_en_i   (irq_en_i),
    .clr_i      (flag_clr_i),
    .pmode_i    (pmode_i),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
  );
endmodule

// File: rtl/cmp_cond_chk.sv
module cmp_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       level_o,
  input logic       flag_o,
  input logic       irq_o,
  input logic       wake_o,
  input logic       edge_fall_i,
  input logic       irq_en_i,
  input logic       flag_clr_i,
  input logic [1:0] pmode_i
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && irq_en_i)); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o); // R5

  AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> (($past(level_o) != $past(level_o, 2)) &&
                       ($past(level_o) != $past(edge_fall_i)))); // R4

  AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(pmode_i) == 2'd1)); // R8

  AST_WAKE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(level_o) != $past(level_o, 2))); // R8
endmodule

bind cmp_cond cmp_cond_chk u_chk (.*);

// File: tb/sim_cmp_cond.sv
module sim_cmp_cond;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmp_raw_i, edge_fall_i, irq_en_i, flag_clr_i;
  logic [1:0] dbsel_i, pmode_i;
  logic       level_o, flag_o, irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  int wake_seen = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_cond u0 (.*);

  // Bench model of the requirements
  logic       m_s1, m_s2, m_filt, m_prev, m_flag, m_wake;
  logic [1:0] m_cnt;

  function automatic logic exp_level(logic sync, logic filt, logic [1:0] sel);
    return (sel == 2'd0) ? sync : filt;
  endfunction

  function automatic logic exp_trig(logic lvl, logic prev, logic fall);
    return (lvl != prev) && (lvl == !fall);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_filt <= 0; m_cnt <= 0;
      m_prev <= 0; m_flag <= 0; m_wake <= 0;
    end else begin
      logic lv;
      lv = exp_level(m_s2, m_filt, dbsel_i);
      m_s1 <= cmp_raw_i;
      m_s2 <= m_s1;
      if (dbsel_i == 2'd0) begin
        m_filt <= m_s2; m_cnt <= 0;
      end else if (m_s2 == m_filt) begin
        m_cnt <= 0;
      end else if (int'(m_cnt) + 1 >= int'(dbsel_i)) begin
        m_filt <= m_s2; m_cnt <= 0;
      end else begin
        m_cnt <= m_cnt + 2'd1;
      end
      m_prev <= lv;
      if (exp_trig(lv, m_prev, edge_fall_i)) m_flag <= 1'b1;
      else if (flag_clr_i)                   m_flag <= 1'b0;
      m_wake <= (lv != m_prev) && (pmode_i == 2'd1);
    end
  end

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #15;
    if (wake_o === 1'b1) wake_seen++;
    if (mon_on) begin
      check("R2 level", level_o, exp_level(m_s2, m_filt, dbsel_i));
      check("R5 flag",  flag_o,  m_flag);
      check("R7 irq",   irq_o,   m_flag && irq_en_i);
      check("R8 wake",  wake_o,  m_wake);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int w0;
    void'($urandom(32'h1234_5678));
    rst_n = 0; cmp_raw_i = 0; dbsel_i = 0; edge_fall_i = 0;
    irq_en_i = 0; flag_clr_i = 0; pmode_i = 2'd1;
    tick(3);
    check("R9 level in reset", level_o, 1'b0);
    check("R9 flag in reset",  flag_o,  1'b0);
    check("R9 irq in reset",   irq_o,   1'b0);
    check("R9 wake in reset",  wake_o,  1'b0);
    rst_n = 1;
    tick(5);
    check("R9 level after reset", level_o, 1'b0);
    check("R9 flag after reset",  flag_o,  1'b0);
    mon_on = 1'b1;

    // R1: no filtering, two-stage latency
    cmp_raw_i = 1;
    tick(); check("R1 level after 1 edge", level_o, 1'b0);
    tick(); check("R1 level after 2 edges", level_o, 1'b1);
    w0 = wake_seen;
    // R6: clear lands on the setting edge
    flag_clr_i = 1;
    tick(); check("R6 flag set beats clear", flag_o, 1'b1);
    check("R8 sleep wake pulse", wake_o, 1'b1);
    flag_clr_i = 0;
    tick(); check("R8 wake single cycle", wake_o, 1'b0);
    irq_en_i = 1;
    tick(); check("R7 irq with flag and enable", irq_o, 1'b1);
    flag_clr_i = 1;
    tick(); check("R5 flag cleared", flag_o, 1'b0);
    flag_clr_i = 0;

    // R4: falling selected, rising edge ignored at the flag
    edge_fall_i = 1; cmp_raw_i = 0; tick(6);
    check("R4 flag on falling edge", flag_o, 1'b1);
    flag_clr_i = 1; tick(); flag_clr_i = 0;
    cmp_raw_i = 1; tick(6);
    check("R4 rising edge ignored", flag_o, 1'b0);

    // R2: hold of three
    dbsel_i = 2'd3; tick(2);
    cmp_raw_i = 0;
    tick(4); check("R2 level held before 3 edges", level_o, 1'b1);
    tick();  check("R2 level after 3 edges", level_o, 1'b0);

    // R3: glitch shorter than hold
    dbsel_i = 2'd2; tick(2);
    cmp_raw_i = 1; tick(); cmp_raw_i = 0;
    tick(8); check("R3 short glitch filtered", level_o, 1'b0);

    // R8: deep sleep suppresses wake
    pmode_i = 2'd2; dbsel_i = 2'd0; w0 = wake_seen;
    cmp_raw_i = 1; tick(6); cmp_raw_i = 0; tick(6);
    check("R8 no wake in deep sleep", wake_seen != w0, 1'b0);

    // Random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) dbsel_i = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0)  pmode_i = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 149) == 0) edge_fall_i = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 49) == 0)  irq_en_i = 1'($urandom_range(0, 1));
      flag_clr_i = ($urandom_range(0, 19) == 0);
      if ((i / 40) % 2 == 0) begin
        if ($urandom_range(0, 1) == 0) cmp_raw_i = ~cmp_raw_i;
      end else if ($urandom_range(0, 15) == 0) begin
        cmp_raw_i = ~cmp_raw_i;
      end
      tick();
    end
    flag_clr_i = 0;
    tick(4);
    done = 1'b1;
    summary();
  end
endmodule